// File: doc/BRIEF.md
# Signed Shift-Add Multiplier

This block multiplies two signed 16-bit operands and returns their signed 32-bit product. It works iteratively, using shift and add. Each iteration passes the running sum through a chain of four carry-save rows. Each row takes one multiplier bit, adds the matching partial product, and retires one finished low product bit. The running sum stays in redundant sum/carry form across iterations. A single extra cycle then does the one carry-propagate addition and applies a fixed sign correction.

Every row is only one bit wider than the operand. Signed weighting is handled inside the rows: the top cell of each partial product sees an inverted sign bit, and the row for the multiplier's most significant bit subtracts the multiplicand instead of adding it. The constant offsets that this introduces are removed in the resolve cycle. As a result, no operand or partial product is ever sign-extended to the 32-bit result width.

A caller presents the operands with a one-cycle `start`. The operation then runs without any further input. `done` pulses for one cycle when `product` holds the new result. A start that arrives during an operation has no effect.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst_n` is low, `done` is 0 and `product` is 0.
- R2: When `done` is high, `product` equals the signed product of the `op_a` and `op_b` values sampled with the accepted `start`, as a 32-bit two's-complement value.
- R3: `done` goes high on the fifth rising edge after the edge that samples an accepted `start`: four iterations of four rows each, then one resolve cycle.
- R4: `done` stays high for exactly one cycle per operation.
- R5: A `start` sampled while an operation is in progress is ignored. It produces no extra `done` pulse and does not change the result of the running operation.
- R6: `product` changes only on the edge that raises `done`, and otherwise holds its last result.
- R7: The extreme operands are exact: -32768 × -32768 gives 0x40000000, and -32768 × 32767 gives 0xC0008000.
- R8: A zero operand on either side gives a product of 0, whatever the sign of the other operand.
- R9: A `start` sampled on the first edge after `done` rises is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when the block is idle |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| done | output | 1 | One-cycle pulse: `product` is new |
| product | output | 32 | Signed product, held until the next result |

## Verification
The bench goes after -32768 × -32768 and most-negative × most-positive. A design that adds the top multiplier row instead of subtracting it, or that loses the sign correction, returns a negative or wrapped value for these. Zero operands paired with negative values catch a design that leaves a residue of the sign-bias constant behind. A start pulse in the middle of a run checks that the operand registers are not reloaded; a design that reloads them would return a mixed result or a second `done`. Back-to-back starts, timed on the cycle `done` is seen, expose a state machine that needs an idle cycle between operations.

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int WIDTH = 16,
  parameter int ROWS  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [WIDTH-1:0]     op_a,
  input  logic [WIDTH-1:0]     op_b,
  output logic                 done,
  output logic [2*WIDTH-1:0]   product
);
  localparam int ITERS = WIDTH / ROWS;
  localparam int CNTW  = $clog2(ITERS) + 1;
  localparam int PW    = 2 * WIDTH;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} st_t;

  st_t              st;
  logic             idle;
  logic             accept;
  logic             last_iter;
  logic [WIDTH-1:0] a_q, b_q, lo_q;
  logic             b_sign_q;
  logic [WIDTH:0]   s_q, c_q;
  logic [CNTW-1:0]  cnt_q;

  logic [WIDTH:0]   s_w [ROWS+1];
  logic [WIDTH:0]   c_w [ROWS+1];
  logic [ROWS-1:0]  out_w;
  logic [WIDTH-1:0] hi_w;
  logic [PW-1:0]    fixed_w;

  assign idle      = (st == S_IDLE);
  assign accept    = start && idle;
  assign last_iter = (cnt_q == CNTW'(ITERS - 1));

  assign s_w[0] = s_q;
  assign c_w[0] = c_q;

  for (genvar j = 0; j < ROWS; j++) begin : g_row
    logic             neg_row;
    logic [WIDTH-1:0] pick;
    logic [WIDTH:0]   z, sum, maj;
    assign neg_row = last_iter && (j == ROWS - 1);
    assign pick    = b_q[j] ? (neg_row ? ~a_q : a_q) : '0;
    assign z       = {1'b0, pick ^ {1'b1, {(WIDTH-1){1'b0}}}};
    assign sum     = s_w[j] ^ c_w[j] ^ z;
    assign maj     = (s_w[j] & c_w[j]) | (s_w[j] & z) | (c_w[j] & z);
    assign out_w[j]  = sum[0];
    assign s_w[j+1]  = {1'b0, sum[WIDTH:1]};
    assign c_w[j+1]  = maj;
  end

  assign hi_w    = s_q[WIDTH-1:0] + c_q[WIDTH-1:0];
  assign fixed_w = {hi_w, lo_q}
                 + {1'b1, {(PW-1){1'b0}}}
                 + (b_sign_q ? (PW'(1) << WIDTH) : (PW'(1) << (WIDTH - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      a_q      <= '0;
      b_q      <= '0;
      lo_q     <= '0;
      b_sign_q <= 1'b0;
      s_q      <= '0;
      c_q      <= '0;
      cnt_q    <= '0;
      done     <= 1'b0;
      product  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          a_q      <= op_a;
          b_q      <= op_b;
          b_sign_q <= op_b[WIDTH-1];
          s_q      <= '0;
          c_q      <= '0;
          lo_q     <= '0;
          cnt_q    <= '0;
          st       <= S_RUN;
        end
        S_RUN: begin
          s_q   <= s_w[ROWS];
          c_q   <= c_w[ROWS];
          lo_q  <= {out_w, lo_q[WIDTH-1:ROWS]};
          b_q   <= b_q >> ROWS;
          cnt_q <= cnt_q + 1'b1;
          if (last_iter) st <= S_FIX;
        end
        S_FIX: begin
          product <= fixed_w;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk #(
  parameter int WIDTH = 16,
  parameter int ROWS  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               idle,
  input logic [WIDTH-1:0]   op_a,
  input logic [WIDTH-1:0]   op_b,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);
  localparam int ITERS = WIDTH / ROWS;
  localparam int CW    = $clog2(ITERS + 2) + 1;
  localparam int PW    = 2 * WIDTH;

  logic             pend;
  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] ca, cb;
  logic [PW-1:0]    exp_p;

  assign exp_p = PW'($signed({{WIDTH{ca[WIDTH-1]}}, ca}) * $signed({{WIDTH{cb[WIDTH-1]}}, cb}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      cnt  <= '0;
      ca   <= '0;
      cb   <= '0;
    end else if (start && idle) begin
      pend <= 1'b1;
      cnt  <= '0;
      ca   <= op_a;
      cb   <= op_b;
    end else if (done) begin
      pend <= 1'b0;
    end else if (pend) begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r2_product_matches: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> product == exp_p);
  a_r3_done_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && cnt == CW'(ITERS + 1)) |-> done);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_only_when_due: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pend && cnt == CW'(ITERS + 1)));
  a_r6_product_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(product) |-> done);
endmodule

bind shift_add_mult shift_add_mult_chk #(.WIDTH(WIDTH), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .idle(idle),
  .op_a(op_a), .op_b(op_b), .done(done), .product(product)
);

// File: tb/test_shift_add_mult.sv
`timescale 1ns/1ps
module test_shift_add_mult;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        done;
  logic [31:0] product;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int exp_q[$];
  string tag_q[$];
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  shift_add_mult i_shift_add_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .done(done), .product(product)
  );

  task automatic check(input bit ok, input string req, input int got, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(0, "R5 unexpected done", int'(product), 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(product == e, t, int'(product), e);
      end
    end
  end

  // Caller is at a negedge; returns at the negedge where done is first seen.
  task automatic do_op(input logic [15:0] a, input logic [15:0] b, input string tag,
                       input bit noise);
    int lat;
    start = 1'b1;
    op_a  = a;
    op_b  = b;
    exp_q.push_back(int'($signed(a)) * int'($signed(b)));
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    op_a  = ~a;
    op_b  = b ^ 16'h5a5a;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (noise && lat == 2) start = 1'b1;
      else start = 1'b0;
    end while (!done && lat < 50);
    start = 1'b0;
    check(lat == 5, "R3 latency", lat, 5);
  endtask

  function automatic logic [15:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[30:15];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(product == 32'd0, "R1 product in reset", int'(product), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 extremes
    do_op(16'h8000, 16'h8000, "R7 min*min", 0);
    check(product == 32'h4000_0000, "R7 min*min value", int'(product), 32'h4000_0000);
    @(negedge clk);
    check(done == 1'b0, "R4 done one cycle", int'(done), 0);
    do_op(16'h8000, 16'h7fff, "R7 min*max", 0);
    check(product == 32'hC000_8000, "R7 min*max value", int'(product), 32'hC000_8000);
    @(negedge clk);
    do_op(16'h7fff, 16'h8000, "R7 max*min", 0);
    @(negedge clk);
    do_op(16'h7fff, 16'h7fff, "R2 max*max", 0);
    @(negedge clk);

    // R8 zeros
    do_op(16'h0000, 16'h8000, "R8 zero*min", 0);
    check(product == 32'd0, "R8 zero value", int'(product), 0);
    @(negedge clk);
    do_op(16'hffff, 16'h0000, "R8 neg*zero", 0);
    @(negedge clk);
    do_op(16'h0000, 16'h0000, "R8 zero*zero", 0);
    @(negedge clk);

    // R2 small signs
    do_op(16'hffff, 16'hffff, "R2 -1*-1", 0);
    @(negedge clk);
    do_op(16'h0001, 16'hffff, "R2 1*-1", 0);
    @(negedge clk);
    do_op(16'hfff3, 16'h0007, "R2 -13*7", 0);
    @(negedge clk);

    // R5 start during run, then R6 hold and no stray done
    do_op(16'h1234, 16'hf00d, "R5 noisy start", 1);
    begin
      logic [31:0] held;
      held = product;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        check(done == 1'b0, "R5 no extra done", int'(done), 0);
        check(product == held, "R6 product held", int'(product), int'(held));
      end
    end

    // R9 back-to-back chain
    do_op(16'h0101, 16'h8001, "R9 chain 0", 0);
    do_op(16'hbeef, 16'h4321, "R9 chain 1", 0);
    do_op(16'h8000, 16'hffff, "R9 chain 2", 0);
    @(negedge clk);

    // R2 pseudo-random patterns
    for (int n = 0; n < 30; n++) begin
      do_op(rnd(), rnd(), "R2 random", 0);
      @(negedge clk);
    end

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule